// File: doc/BRIEF.md
# Maximal-Length Shift-Register Counter

This block is a counter built from a shift register. It has no adder and no general next-state logic. A single feedback bit, formed as the XOR of a few fixed register stages, enters at one end of the register. Every other stage copies its neighbour. The register length is chosen at elaboration time and may be any value from 2 to 8. For each length, a built-in tap set makes the counter pass through every non-zero state exactly once before it repeats. The period is therefore 2^n−1 clock steps.

Typical uses are cheap pseudo-random sequences, long dividers with minimal logic, and test-pattern generation. A count-enable input gates each step. A one-cycle flag marks the step on which the state returns to its starting value, so it can serve as a divide-by-(2^n−1) tick.

Top module: `lfsr_seq_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state loads the seed and `wrap_pulse` goes to 0. The seed has bit n−1 set to 1 and all other bits 0; `state_q[i]` holds stage Xi. Reset wins over `step_en`.
- R2: When `step_en` is low and reset is inactive, `state_q` keeps its value and `wrap_pulse` is 0.
- R3: On an enabled edge, each stage Xi takes the old value of X(i+1) for i < n−1, and stage X(n−1) takes the feedback bit.
- R4: The feedback bit is the XOR of these stages: X1,X0 for n = 2, 3, 4 and 6; X2,X0 for n = 5; X3,X0 for n = 7; X4,X3,X2,X0 for n = 8.
- R5: Starting from the seed, the first 2^n−1 enabled steps visit distinct states, and step 2^n−1 lands on the seed again.
- R6: `wrap_pulse` is 1 for exactly one cycle, in the cycle after an enabled edge that loads the seed. At all other times it is 0.
- R7: After reset, `state_q` is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the seed |
| step_en | input | 1 | Advance the sequence by one step on this edge |
| state_q | output | WIDTH | Current register contents, bit i is stage Xi |
| wrap_pulse | output | 1 | One-cycle flag, state has just returned to the seed |

## Verification
The bench builds one instance for every legal length, 2 through 8, side by side. A single enable window of 255 steps covers the whole period of each instance, so the tap set for each length is checked against an independent model. The same window checks that no state repeats and that the seed and flag return on the exact step. A further instance at the default length of 8 takes the directed scenarios: reset priority over enable, holding with enable low, and dropping enable right after the wrap.

// File: rtl/lfsr_cnt_pkg.sv
// Package: shared constants and per-length tap/seed lookups.
// Assumes callers pass a length inside MIN_LEN..MAX_LEN; other values
// return an all-zero mask so the top-level range check is the only guard.
package lfsr_cnt_pkg;

    localparam int MIN_LEN = 2;
    localparam int MAX_LEN = 8;

    // Tap mask: bit i set means stage Xi feeds the XOR.
    function automatic logic [MAX_LEN-1:0] tap_mask(input int len);
        logic [MAX_LEN-1:0] m;
        case (len)
            2, 3, 4, 6: m = 8'b0000_0011;
            5:          m = 8'b0000_0101;
            7:          m = 8'b0000_1001;
            8:          m = 8'b0001_1101;
            default:    m = 8'b0000_0000;
        endcase
        return m;
    endfunction

    // Seed: only the input-end stage X(len-1) is set.
    function automatic logic [MAX_LEN-1:0] seed_word(input int len);
        logic [MAX_LEN-1:0] s;
        s = '0;
        s[len-1] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/lfsr_tap_xor.sv
// Module: forms the serial feedback bit as the modulo-2 sum of the
// stages chosen by the tap table for this WIDTH.
// Assumes WIDTH is within the supported range; purely combinational.
module lfsr_tap_xor
    import lfsr_cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_state,
    output logic             fb_bit
);

    localparam logic [MAX_LEN-1:0] MASK_FULL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0]   MASK      = MASK_FULL[WIDTH-1:0];

    logic [WIDTH-1:0] tapped;

    // One AND gate per stage; unused stages fold to constant zero.
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        assign tapped[i] = cur_state[i] & MASK[i];
    end

    // Reduce the tapped stages to the feedback bit.
    always_comb begin
        fb_bit = ^tapped;
    end

endmodule

// File: rtl/lfsr_shift_core.sv
// Module: the state register. Shifts from X(WIDTH-1) toward X0 on each
// enabled edge, loading the feedback bit at the input end.
// Assumes synchronous active-low reset; reset has priority over enable.
module lfsr_shift_core
    import lfsr_cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             fb_bit,
    output logic [WIDTH-1:0] state_q
);

    localparam logic [MAX_LEN-1:0] SEED_FULL = seed_word(WIDTH);
    localparam logic [WIDTH-1:0]   SEED      = SEED_FULL[WIDTH-1:0];

    // Register update: reset to seed, else shift when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step_en) begin
            state_q <= {fb_bit, state_q[WIDTH-1:1]};
        end
    end

    // R1: reset always leaves the seed behind
    a_r1_seed_after_reset: assert property (@(posedge clk)
        !rst_n |=> state_q == SEED);

    // R2: idle edges keep the state unchanged
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !step_en) |=> $stable(state_q));

    // R3: enabled edges move every stage one place toward X0
    a_r3_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && step_en) |=> state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1]));

    // R7: the lock-up state is never reached
    a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state_q != '0);

endmodule

// File: rtl/lfsr_wrap_flag.sv
// Module: raises a one-cycle flag after an enabled edge that reloads
// the seed. It also keeps a step counter used only by the period check.
// Assumes nxt_state is the value the core loads on an enabled edge.
module lfsr_wrap_flag
    import lfsr_cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [WIDTH-1:0] nxt_state,
    output logic             wrap_pulse
);

    localparam logic [MAX_LEN-1:0] SEED_FULL = seed_word(WIDTH);
    localparam logic [WIDTH-1:0]   SEED      = SEED_FULL[WIDTH-1:0];
    localparam int                 CW        = WIDTH + 1;
    localparam logic [CW-1:0]      PERIOD    = CW'((1 << WIDTH) - 1);

    logic          hits_seed;
    logic [CW-1:0] steps_since;

    // Detect that the coming step returns to the seed.
    always_comb begin
        hits_seed = (nxt_state == SEED);
    end

    // Registered flag, high only after a seed-loading step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= step_en && hits_seed;
        end
    end

    // Steps taken since the seed was last present (period check only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_since <= '0;
        end else if (step_en) begin
            steps_since <= hits_seed ? '0 : steps_since + 1'b1;
        end
    end

    // R5: the seed comes back only after a full period of steps
    a_r5_full_period: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && hits_seed) |-> steps_since == PERIOD - 1'b1);

    // R6: the flag never lasts two cycles
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);

    // R6: the flag only follows an enabled edge
    a_r6_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_pulse) |-> $past(step_en));

endmodule

// File: rtl/lfsr_seq_counter.sv
// Module: top of the maximal-length shift-register counter. Ties the
// tap XOR, the state register and the wrap flag together.
// Assumes WIDTH in 2..8; other values stop elaboration.
module lfsr_seq_counter
    import lfsr_cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [WIDTH-1:0] state_q,
    output logic             wrap_pulse
);

    localparam logic [MAX_LEN-1:0] SEED_FULL = seed_word(WIDTH);
    localparam logic [WIDTH-1:0]   SEED      = SEED_FULL[WIDTH-1:0];

    if (WIDTH < MIN_LEN || WIDTH > MAX_LEN) begin : g_bad_width
        $error("lfsr_seq_counter: WIDTH must lie in 2..8");
    end

    logic             fb_bit;
    logic [WIDTH-1:0] nxt_state;

    lfsr_tap_xor #(.WIDTH(WIDTH)) u_taps (
        .cur_state (state_q),
        .fb_bit    (fb_bit)
    );

    lfsr_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .fb_bit  (fb_bit),
        .state_q (state_q)
    );

    // Value the core loads on the next enabled edge.
    always_comb begin
        nxt_state = {fb_bit, state_q[WIDTH-1:1]};
    end

    lfsr_wrap_flag #(.WIDTH(WIDTH)) u_wrap (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .nxt_state  (nxt_state),
        .wrap_pulse (wrap_pulse)
    );

    // R6: a raised flag always shows the seed on the state port
    a_r6_flag_with_seed: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> state_q == SEED);

endmodule

// File: tb/sim_lfsr_seq_counter.sv
module sim_lfsr_seq_counter;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Default-length instance for directed scenarios
    logic       rst0_n, en0;
    logic [7:0] st0;
    logic       wr0;

    lfsr_seq_counter u0 (
        .clk(clk), .rst_n(rst0_n), .step_en(en0),
        .state_q(st0), .wrap_pulse(wr0)
    );

    // One instance per legal length for the period sweep
    logic       rsta_n, ena;
    logic [7:0] st_w [2:8];
    logic       wr_w [2:8];

    for (genvar w = 2; w <= 8; w++) begin : g_len
        logic [w-1:0] s;
        logic         p;
        lfsr_seq_counter #(.WIDTH(w)) u_len (
            .clk(clk), .rst_n(rsta_n), .step_en(ena),
            .state_q(s), .wrap_pulse(p)
        );
        assign st_w[w] = 8'(s);
        assign wr_w[w] = p;
    end

    // Tap sets from R4, written independently
    function automatic logic [7:0] ref_taps(input int w);
        case (w)
            5:       return 8'h05;
            7:       return 8'h09;
            8:       return 8'h1D;
            default: return 8'h03;
        endcase
    endfunction

    function automatic logic [7:0] ref_next(input int w, input logic [7:0] s);
        logic b;
        b = ^(s & ref_taps(w));
        return (s >> 1) | (8'(b) << (w - 1));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // R1: reset with enable high still loads the seed
    task automatic t_reset_state();
        rst0_n = 1'b0; en0 = 1'b1;
        repeat (3) @(negedge clk);
        chk(st0 == 8'h80, "R1", "seed after reset", st0, 8'h80);
        chk(wr0 == 1'b0, "R1", "flag after reset", wr0, 0);
    endtask

    // R3/R4: twenty enabled steps follow the reference recurrence
    task automatic t_step_sequence();
        logic [7:0] m;
        m = 8'h80;
        rst0_n = 1'b1; en0 = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            m = ref_next(8, m);
            chk(st0 == m, "R3", "shifted state", st0, m);
        end
    endtask

    // R2: idle cycles hold the state, then one step resumes correctly
    task automatic t_hold();
        logic [7:0] keep;
        keep = st0;
        en0 = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(st0 == keep, "R2", "held state", st0, keep);
            chk(wr0 == 1'b0, "R2", "flag while idle", wr0, 0);
        end
        en0 = 1'b1;
        @(negedge clk);
        en0 = 1'b0;
        chk(st0 == ref_next(8, keep), "R3", "step after hold", st0, ref_next(8, keep));
    endtask

    // R1: reset in mid-run overrides a high enable
    task automatic t_reset_midrun();
        en0 = 1'b1;
        repeat (7) @(negedge clk);
        rst0_n = 1'b0;
        @(negedge clk);
        chk(st0 == 8'h80, "R1", "seed after mid-run reset", st0, 8'h80);
        rst0_n = 1'b1;
        en0 = 1'b0;
        @(negedge clk);
    endtask

    // R6: flag at the wrap, then drops when enable falls
    task automatic t_wrap_then_hold();
        rst0_n = 1'b0;
        @(negedge clk);
        rst0_n = 1'b1; en0 = 1'b1;
        for (int k = 1; k <= 255; k++) begin
            @(negedge clk);
            if (k == 254) chk(wr0 == 1'b0, "R6", "flag before wrap", wr0, 0);
        end
        chk(wr0 == 1'b1, "R6", "flag at wrap", wr0, 1);
        chk(st0 == 8'h80, "R6", "seed at wrap", st0, 8'h80);
        en0 = 1'b0;
        @(negedge clk);
        chk(wr0 == 1'b0, "R6", "flag one cycle later", wr0, 0);
        chk(st0 == 8'h80, "R2", "seed held after wrap", st0, 8'h80);
    endtask

    // R4/R5/R6/R7: full period for every length in one window
    task automatic t_full_period();
        logic [255:0] seen [2:8];
        logic [7:0]   cur  [2:8];
        rsta_n = 1'b0; ena = 1'b1;
        repeat (2) @(negedge clk);
        for (int w = 2; w <= 8; w++) begin
            chk(st_w[w] == (8'h01 << (w - 1)), "R1", "seed per length", st_w[w], 8'h01 << (w - 1));
            cur[w]  = 8'h01 << (w - 1);
            seen[w] = '0;
            seen[w][cur[w]] = 1'b1;
        end
        rsta_n = 1'b1;
        for (int k = 1; k <= 255; k++) begin
            @(negedge clk);
            for (int w = 2; w <= 8; w++) begin
                int per;
                per = (1 << w) - 1;
                if (k <= per) begin
                    cur[w] = ref_next(w, cur[w]);
                    chk(st_w[w] == cur[w], "R4", "tap sequence", st_w[w], cur[w]);
                    chk(st_w[w] != 8'h00, "R7", "nonzero state", st_w[w], 1);
                    if (k < per) begin
                        chk(!seen[w][st_w[w]], "R5", "state repeated early", st_w[w], 0);
                        chk(wr_w[w] == 1'b0, "R6", "flag before period", wr_w[w], 0);
                    end else begin
                        chk(st_w[w] == (8'h01 << (w - 1)), "R5", "seed at period end", st_w[w], 8'h01 << (w - 1));
                        chk(wr_w[w] == 1'b1, "R6", "flag at period end", wr_w[w], 1);
                    end
                    seen[w][st_w[w]] = 1'b1;
                end
            end
        end
        ena = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst0_n = 1'b0; en0 = 1'b0;
        rsta_n = 1'b0; ena = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_step_sequence();
        t_hold();
        t_reset_midrun();
        t_wrap_then_hold();
        t_full_period();
        finish_run();
    end

endmodule